// File: doc/BRIEF.md
# Flash Erase Control Register

A single 32-bit control register that sits between software and the flash sequencer of an embedded flash controller. Software sets up a page erase or a mass erase by writing the page number, the bank target and the mass-erase flags. It then launches the erase by writing a 1 to the erase-start bit. A separate start bit launches an option-change operation. The register also stores the program enable, the page-erase enable, the fast-programming enable and two interrupt enables.

A 0-to-1 change of either start bit produces a one-cycle request toward the sequencer. An erase request carries the page, the effective bank and the mass-erase flags. An erase start that names a page beyond the main array, with no mass erase selected, is refused: the block raises a one-cycle page error instead of a request. The start bits stay set while the sequencer works. Hardware clears them when the sequencer's per-bank busy flags fall. A single interrupt output combines the completion and error flags with their enables.

Register bit positions: 0 program enable, 1 page-erase enable, 2 bank-1 mass erase, 12:3 page number, 13 bank select, 15 bank-2 mass erase, 16 erase start, 17 option start, 18 fast-programming enable, 24 completion interrupt enable, 25 error interrupt enable. Bits 14, 23:19 and 31:26 are reserved and read as zero.

Top module: `flash_cmd_regs`

## Requirements
- R1: After reset, `rd_data` reads 0, and `erase_req`, `opt_req`, `page_err` and `irq` are all 0.
- R2: A write stores bits 0–13, 15, 18, 24 and 25 as written. The reserved bits (14, 23:19, 31:26) read 0 whatever is written.
- R3: The erase-start bit (bit 16) is set only by a write with bit 16 = 1. A write with bit 16 = 0 leaves it unchanged.
- R4: The erase-start bit clears one cycle after either `bank1_busy` or `bank2_busy` goes from 1 to 0.
- R5: The option-start bit (bit 17) clears one cycle after `bank1_busy` falls. A fall of `bank2_busy` alone does not clear it.
- R6: A write that takes the erase-start bit from 0 to 1 drives `erase_req` high for exactly the next cycle. `erase_page` then shows the written bits 12:3, `erase_mass1` bit 2 and `erase_mass2` bit 15.
- R7: `erase_bank` equals written bit 13 (0 = bank 1, 1 = bank 2) when `DUAL_BANK` = 1. It is always 0 in a single-bank build, where `erase_mass2` is also 0.
- R8: An erase start with page > `MAX_PAGE` (default 383) and neither mass flag set gives no `erase_req`. Instead `page_err` pulses for one cycle, and the erase-start bit stays 0. Page 383 itself is legal.
- R9: A write that takes the option-start bit from 0 to 1 drives `opt_req` high for exactly the next cycle.
- R10: `irq` = (bit 25 AND `operr_flag`) OR (bit 24 AND `eop_flag`).
- R11: A write setting a start bit in the same cycle as a busy fall that would clear that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| bank1_busy | input | 1 | Sequencer busy flag, bank 1 |
| bank2_busy | input | 1 | Sequencer busy flag, bank 2 |
| eop_flag | input | 1 | Sequencer end-of-operation flag |
| operr_flag | input | 1 | Sequencer operation-error flag |
| erase_req | output | 1 | One-cycle erase request |
| erase_page | output | 10 | Page number of the request |
| erase_bank | output | 1 | Effective bank of the request (0 = bank 1) |
| erase_mass1 | output | 1 | Mass erase of bank 1 requested |
| erase_mass2 | output | 1 | Mass erase of bank 2 requested |
| page_err | output | 1 | One-cycle refused-erase indication |
| opt_req | output | 1 | One-cycle option-change request |
| irq | output | 1 | Interrupt output |

## Verification
A software write that sets a start bit and a busy falling edge that clears the same bit can land in one clock cycle. The bench provokes this by dropping `bank1_busy` on the same edge that carries the start write. It checks that the bit reads back as set afterwards. It runs the case twice. When the bit was clear before the write, a fresh request must also appear. When the bit was already set, the write must leave it set and issue no second request.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned PAGE_W      = 10;
  localparam int unsigned POS_MASS1   = 2;
  localparam int unsigned POS_PAGE_LO = 3;
  localparam int unsigned POS_PAGE_HI = POS_PAGE_LO + PAGE_W - 1;
  localparam int unsigned POS_BANK    = 13;
  localparam int unsigned POS_MASS2   = 15;
  localparam int unsigned POS_ESTART  = 16;
  localparam int unsigned POS_OSTART  = 17;
  localparam int unsigned POS_EOPIE   = 24;
  localparam int unsigned POS_ERRIE   = 25;
  // plain stored fields: enables, page, bank, mass flags, fast, irq enables
  localparam logic [REG_W-1:0] FIELD_MASK = 32'h0304_BFFF;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic              bank;
    logic              mass1;
    logic              mass2;
  } erase_cmd_t;
endpackage

// File: rtl/flash_cmd_busy_edge.sv
module flash_cmd_busy_edge #(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] busy,
  output logic [NUM_BANKS-1:0] fall
);
  logic [NUM_BANKS-1:0] busy_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q[b] <= 1'b0;
      else        busy_q[b] <= busy[b];
    end
    assign fall[b] = busy_q[b] & ~busy[b];
  end
endmodule

// File: rtl/flash_cmd_launch.sv
module flash_cmd_launch
  import flash_cmd_pkg::*;
#(
  parameter bit          DUAL_BANK = 1'b1,
  parameter int unsigned MAX_PAGE  = 383
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             estart_q,
  input  logic             ostart_q,
  output logic             estart_set,
  output logic             ostart_set,
  output logic             erase_req,
  output erase_cmd_t       erase_cmd,
  output logic             page_err,
  output logic             opt_req
);
  erase_cmd_t cmd_d, cmd_q;
  logic       legal, erase_rise, page_fail, opt_rise;
  logic       req_q, err_q, opt_q;

  always_comb begin
    cmd_d.page  = wr_data[POS_PAGE_HI:POS_PAGE_LO];
    cmd_d.mass1 = wr_data[POS_MASS1];
    cmd_d.bank  = DUAL_BANK ? wr_data[POS_BANK]  : 1'b0;
    cmd_d.mass2 = DUAL_BANK ? wr_data[POS_MASS2] : 1'b0;
  end

  assign legal      = cmd_d.mass1 | cmd_d.mass2 | (32'(cmd_d.page) <= MAX_PAGE);
  assign estart_set = wr_en & wr_data[POS_ESTART] & legal;
  assign ostart_set = wr_en & wr_data[POS_OSTART];
  assign erase_rise = estart_set & ~estart_q;
  assign page_fail  = wr_en & wr_data[POS_ESTART] & ~estart_q & ~legal;
  assign opt_rise   = ostart_set & ~ostart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      opt_q <= 1'b0;
    end else begin
      req_q <= erase_rise;
      err_q <= page_fail;
      opt_q <= opt_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmd_q <= '0;
    else if (erase_rise) cmd_q <= cmd_d;
  end

  assign erase_req = req_q;
  assign erase_cmd = cmd_q;
  assign page_err  = err_q;
  assign opt_req   = opt_q;
endmodule

// File: rtl/flash_cmd_irq.sv
module flash_cmd_irq (
  input  logic eop_en,
  input  logic err_en,
  input  logic eop_flag,
  input  logic operr_flag,
  output logic irq
);
  assign irq = (err_en & operr_flag) | (eop_en & eop_flag);
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter bit          DUAL_BANK = 1'b1,
  parameter int unsigned MAX_PAGE  = 383
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              bank1_busy,
  input  logic              bank2_busy,
  input  logic              eop_flag,
  input  logic              operr_flag,
  output logic              erase_req,
  output logic [PAGE_W-1:0] erase_page,
  output logic              erase_bank,
  output logic              erase_mass1,
  output logic              erase_mass2,
  output logic              page_err,
  output logic              opt_req,
  output logic              irq
);
  localparam int unsigned NUM_BANKS = 2;

  logic [REG_W-1:0]     fields_q, fields_d;
  logic                 estart_q, estart_d, ostart_q, ostart_d;
  logic                 estart_set, ostart_set;
  logic [NUM_BANKS-1:0] busy_fall;
  erase_cmd_t           cmd;

  flash_cmd_busy_edge #(.NUM_BANKS(NUM_BANKS)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .busy ({bank2_busy, bank1_busy}),
    .fall (busy_fall)
  );

  flash_cmd_launch #(.DUAL_BANK(DUAL_BANK), .MAX_PAGE(MAX_PAGE)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .estart_q  (estart_q),
    .ostart_q  (ostart_q),
    .estart_set(estart_set),
    .ostart_set(ostart_set),
    .erase_req (erase_req),
    .erase_cmd (cmd),
    .page_err  (page_err),
    .opt_req   (opt_req)
  );

  // next state: software set has priority over hardware clear
  always_comb begin
    fields_d = wr_en ? (wr_data & FIELD_MASK) : fields_q;
    if (estart_set)     estart_d = 1'b1;
    else if (|busy_fall) estart_d = 1'b0;
    else                estart_d = estart_q;
    if (ostart_set)        ostart_d = 1'b1;
    else if (busy_fall[0]) ostart_d = 1'b0;
    else                   ostart_d = ostart_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      estart_q <= 1'b0;
      ostart_q <= 1'b0;
    end else begin
      fields_q <= fields_d;
      estart_q <= estart_d;
      ostart_q <= ostart_d;
    end
  end

  always_comb begin
    rd_data             = fields_q;
    rd_data[POS_ESTART] = estart_q;
    rd_data[POS_OSTART] = ostart_q;
  end

  flash_cmd_irq u_irq (
    .eop_en    (fields_q[POS_EOPIE]),
    .err_en    (fields_q[POS_ERRIE]),
    .eop_flag  (eop_flag),
    .operr_flag(operr_flag),
    .irq       (irq)
  );

  assign erase_page  = cmd.page;
  assign erase_bank  = cmd.bank;
  assign erase_mass1 = cmd.mass1;
  assign erase_mass2 = cmd.mass2;
endmodule

// File: rtl/flash_cmd_regs_chk.sv
module flash_cmd_regs_chk #(
  parameter int unsigned MAX_PAGE = 383
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        bank1_busy,
  input logic        bank2_busy,
  input logic        eop_flag,
  input logic        operr_flag,
  input logic        erase_req,
  input logic [9:0]  erase_page,
  input logic        erase_mass1,
  input logic        erase_mass2,
  input logic        page_err,
  input logic        opt_req,
  input logic        irq
);
  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  assert_req_bit_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> rd_data[16]);

  assert_req_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (erase_mass1 || erase_mass2 || (32'(erase_page) <= MAX_PAGE)));

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |-> (!erase_req && !rd_data[16]));

  assert_estart_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[16]) |->
      (($past(bank1_busy, 2) && !$past(bank1_busy)) ||
       ($past(bank2_busy, 2) && !$past(bank2_busy))));

  assert_ostart_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[17]) |-> ($past(bank1_busy, 2) && !$past(bank1_busy)));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[17]) |=> rd_data[17]);

  assert_opt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    opt_req |-> (rd_data[17] && !$past(rd_data[17])));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[24] && !rd_data[25]) |-> !irq);

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (eop_flag || operr_flag));
endmodule

bind flash_cmd_regs flash_cmd_regs_chk #(.MAX_PAGE(MAX_PAGE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .bank1_busy (bank1_busy),
  .bank2_busy (bank2_busy),
  .eop_flag   (eop_flag),
  .operr_flag (operr_flag),
  .erase_req  (erase_req),
  .erase_page (erase_page),
  .erase_mass1(erase_mass1),
  .erase_mass2(erase_mass2),
  .page_err   (page_err),
  .opt_req    (opt_req),
  .irq        (irq)
);

// File: tb/flash_cmd_regs_bench.sv
module flash_cmd_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        bank1_busy = 1'b0, bank2_busy = 1'b0;
  logic        eop_flag = 1'b0, operr_flag = 1'b0;
  logic        erase_req, erase_bank, erase_mass1, erase_mass2;
  logic        page_err, opt_req, irq;
  logic [9:0]  erase_page;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_regs u_flash_cmd_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .bank1_busy(bank1_busy), .bank2_busy(bank2_busy), .eop_flag(eop_flag),
    .operr_flag(operr_flag), .erase_req(erase_req), .erase_page(erase_page),
    .erase_bank(erase_bank), .erase_mass1(erase_mass1), .erase_mass2(erase_mass2),
    .page_err(page_err), .opt_req(opt_req), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic drop_busy(bit b2);
    @(negedge clk); if (b2) bank2_busy = 1'b1; else bank1_busy = 1'b1;
    @(negedge clk); if (b2) bank2_busy = 1'b0; else bank1_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 outputs", {28'h0, erase_req, opt_req, page_err, irq}, 32'h0);
  endtask

  task automatic t_fields;
    write(32'hFFFF_FFFF);
    check("R2 readback", rd_data, 32'h0307_BFFF);
    check("R6 req all-ones", {erase_req, erase_mass1, erase_mass2, erase_bank}, 4'hF);
    check("R6 page all-ones", erase_page, 10'h3FF);
    @(negedge clk);
    check("R6 one cycle", erase_req, 1'b0);
    drop_busy(1'b0);
    check("R4 R5 bank1 fall clears both", rd_data[17:16], 2'b00);
    write(32'h0);
    check("R2 cleared", rd_data, 32'h0);
  endtask

  task automatic t_zero_keeps;
    write(32'h0001_0000 | (32'd5 << 3));
    check("R6 page 5", {erase_req, erase_page, erase_bank, erase_mass1, erase_mass2},
          {1'b1, 10'd5, 3'b000});
    write(32'h0);
    check("R3 zero write keeps start", rd_data, 32'h0001_0000);
    drop_busy(1'b1);
    check("R4 bank2 fall clears", rd_data, 32'h0);
  endtask

  task automatic t_opt;
    write(32'h0002_0000);
    check("R9 opt_req", opt_req, 1'b1);
    @(negedge clk);
    check("R9 one cycle", opt_req, 1'b0);
    drop_busy(1'b1);
    check("R5 bank2 fall keeps opt", rd_data, 32'h0002_0000);
    drop_busy(1'b0);
    check("R5 bank1 fall clears opt", rd_data, 32'h0);
  endtask

  task automatic t_bank;
    write(32'h0001_2000 | (32'd383 << 3));
    check("R7 R8 bank2 page383", {erase_req, erase_bank, erase_page}, {2'b11, 10'd383});
    drop_busy(1'b1);
    write(32'h0);
  endtask

  task automatic t_illegal;
    write(32'h0001_0000 | (32'd384 << 3));
    check("R8 no req", erase_req, 1'b0);
    check("R8 page_err", page_err, 1'b1);
    check("R8 start clear", rd_data, 32'h0000_0C00);
    @(negedge clk);
    check("R8 err one cycle", page_err, 1'b0);
    write(32'h0001_0004 | (32'd384 << 3));
    check("R8 mass legal", {erase_req, erase_mass1, page_err}, 3'b110);
    drop_busy(1'b0);
    write(32'h0);
  endtask

  task automatic t_irq;
    write(32'h0100_0000);
    eop_flag = 1'b1; #1;
    check("R10 eop irq", irq, 1'b1);
    eop_flag = 1'b0; operr_flag = 1'b1; #1;
    check("R10 err disabled", irq, 1'b0);
    write(32'h0300_0000); #1;
    check("R10 err irq", irq, 1'b1);
    write(32'h0); #1;
    check("R10 disabled", irq, 1'b0);
    operr_flag = 1'b0;
  endtask

  task automatic t_collide;
    @(negedge clk); bank1_busy = 1'b1;
    @(negedge clk); bank1_busy = 1'b0; wr_en = 1'b1; wr_data = 32'h0001_0000 | (32'd7 << 3);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R11 set wins fresh", {rd_data[16], erase_req}, 2'b11);
    @(negedge clk); bank1_busy = 1'b1;
    @(negedge clk); bank1_busy = 1'b0; wr_en = 1'b1; wr_data = 32'h0003_0000;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    check("R11 set wins held", {rd_data[17:16], erase_req, opt_req}, 4'b1101);
    drop_busy(1'b0);
    check("R11 later fall clears", rd_data, 32'h0);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_zero_keeps();
    t_opt();
    t_bank();
    t_illegal();
    t_irq();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule